// File: doc/BRIEF.md
# Multi-Mode Timer/Event Counter

This block is an up-counter of configurable width with a preload register and an 8-bit control register. Software reaches both registers over a small synchronous register bus. The counter has three modes:

- **Event mode** counts chosen edges of an external pin.
- **Timer mode** counts ticks of a prescaled internal clock.
- **Pulse-width mode** times one pulse on the external pin, then stops by itself and holds the result.

In every mode, stepping past the all-ones value reloads the counter from the preload register. The same step sets a sticky interrupt-request flag and toggles an output that drives a frequency-divider pin.

The external pin passes through a two-flop synchronizer before edge detection. With a width of 8 or less, the narrow variant is built and the control register carries a 3-bit prescaler field. With a wider counter, the wide variant is built: it has a source-select bit that picks either the system clock divided by 4 or a single-cycle slow-clock tick enable.

Pulse-width measurement is run by a small state machine with three states:

| State | Meaning |
|---|---|
| `PW_IDLE` | Mode not pulse-width, or run bit clear. |
| `PW_ARMED` | Waiting for the starting transition. |
| `PW_MEASURE` | Counting ticks while the level persists. |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| *arm* | `PW_IDLE` | `PW_ARMED` | Pulse mode and run bit both set. |
| *start* | `PW_ARMED` | `PW_MEASURE` | Active edge detected. |
| *finish* | `PW_MEASURE` | `PW_IDLE` | Opposite edge detected; this pulses the hardware clear of the run bit. |
| *abort* | `PW_ARMED` or `PW_MEASURE` | `PW_IDLE` | Run bit cleared or mode changed. |

Top module: `tmr_event_counter`

## Requirements
- R1: Control bits 7:6 pick the mode: 01 event, 10 timer, 11 pulse-width. With 00 the counter never changes, even with the run bit set.
- R2: Control bit 4 is the run bit; with it clear the counter holds its value in every mode.
- R3: In event mode the counter steps once per synchronized edge of `ext_in`. Control bit 3 picks the edge: 0 counts rising edges and 1 counts falling edges. An edge of the other kind is not counted.
- R4: A count step from all-ones loads the counter from the preload register, sets `irq_flag` and toggles `pfd_out`; this holds in all three modes.
- R5: In the narrow variant (width 8 or less), timer mode steps once every 2^n system cycles, where n is control bits 2:0 (0 to 7).
- R6: In the wide variant, timer mode uses control bit 5 as the source select: 0 steps every 4 system cycles and 1 steps once per `slow_tick` pulse.
- R7: In pulse-width mode with the run bit set, counting starts at the active edge selected by bit 3. The counter then advances on each internal tick while the level persists; a level held for N cycles at prescale 0 adds N.
- R8: When a pulse-width measurement ends, hardware clears control bit 4. In event and timer modes the run bit stays set until software writes it.
- R9: After a measurement, later pulses leave the counter unchanged until software sets the run bit again. A fresh measurement then adds to the held value.
- R10: `irq_flag` stays set until a cycle with `irq_clr` high clears it; an overflow in the same cycle wins.
- R11: A write to address 0 updates the preload register. It also loads the counter only while the run bit is 0.
- R12: Reads at address 0 return the counter and reads at address 1 return the control register. Bits the variant does not use read as 0: bit 5 in the narrow variant, bits 2:0 in the wide one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0: counter/preload, 1: control |
| bus_wdata | input | CW | Write data (control uses bits 7:0) |
| bus_rdata | output | CW | Read data, combinational from `bus_addr` |
| ext_in | input | 1 | Raw external pin |
| slow_tick | input | 1 | Single-cycle slow-clock enable |
| irq_clr | input | 1 | Clears the interrupt-request flag |
| irq_flag | output | 1 | Sticky interrupt request |
| pfd_out | output | 1 | Toggles on every overflow |

## Verification
The assertions assume three things about the inputs:

- `ext_in` sits low through reset, so the synchronizer's reset value does not create a false edge.
- `slow_tick` is a single-cycle pulse.
- The control register is not rewritten in the same cycle that a measurement ends.

The bench holds the pin low during reset and spaces slow ticks by idle cycles. It writes the control register only while the pin is idle or well before an edge. Timer windows are exact multiples of the tick period, so the expected count does not depend on the free-running divider's phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        PW_IDLE    = 2'd0,
        PW_ARMED   = 2'd1,
        PW_MEASURE = 2'd2
    } pw_state_e;

    localparam int CTRL_W   = 8;
    localparam int DIV_BITS = 7;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-1:0], pin_i};
    end

    always_comb begin
        level_o = sr_q[STAGES-1];
        rise_o  = sr_q[STAGES-1] & ~sr_q[STAGES];
        fall_o  = ~sr_q[STAGES-1] & sr_q[STAGES];
    end

    // R3: an edge indication never lasts two cycles in a row
    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] psc_i,
    input  logic       src_slow_i,
    input  logic       slow_tick_i,
    output logic       tick_o
);
    localparam bit NARROW = (CW <= 8);

    logic [DIV_BITS-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    generate
        if (NARROW) begin : g_narrow
            logic [DIV_BITS-1:0] mask;
            logic                unused_wide;
            assign mask        = DIV_BITS'((8'd1 << psc_i) - 8'd1);
            assign tick_o      = (div_q & mask) == mask;
            assign unused_wide = ^{src_slow_i, slow_tick_i};

            // R5: with any nonzero prescale, ticks are never adjacent
            a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_o && psc_i != 3'd0) |=> (!tick_o || psc_i == 3'd0));
        end else begin : g_wide
            logic unused_narrow;
            assign tick_o        = src_slow_i ? slow_tick_i : (div_q[1:0] == 2'b11);
            assign unused_narrow = ^{psc_i, div_q[DIV_BITS-1:2]};

            // R6: the divide-by-4 source never ticks twice in a row
            a_r6_sys4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_o && !src_slow_i) |=> (!tick_o || src_slow_i));
        end
    endgenerate
endmodule

// File: rtl/tmr_pw_fsm.sv
module tmr_pw_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pw_en_i,
    input  logic start_i,
    input  logic stop_i,
    output logic measuring_o,
    output logic done_o
);
    pw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE:    if (pw_en_i) state_d = PW_ARMED;
            PW_ARMED:   if (!pw_en_i) state_d = PW_IDLE;
                        else if (start_i) state_d = PW_MEASURE;
            PW_MEASURE: if (!pw_en_i || stop_i) state_d = PW_IDLE;
            default:    state_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        measuring_o = (state_q == PW_MEASURE);
        done_o      = (state_q == PW_MEASURE) && pw_en_i && stop_i;
    end

    // R8: a finished measurement always returns to idle
    a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> state_q == PW_IDLE);
    // R7: measurement is only entered from an armed state on a start edge
    a_r7_measure_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(measuring_o) |-> ($past(start_i) && $past(state_q) == PW_ARMED));
endmodule

// File: rtl/tmr_event_counter.sv
module tmr_event_counter
    import tmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic          bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic          ext_in,
    input  logic          slow_tick,
    input  logic          irq_clr,
    output logic          irq_flag,
    output logic          pfd_out
);
    localparam bit              NARROW    = (CW <= 8);
    localparam logic [CTRL_W-1:0] CTRL_MASK = NARROW ? 8'hDF : 8'hF8;
    localparam logic [CW-1:0]   CNT_MAX   = '1;

    logic [CW-1:0]     cnt_q, preload_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              irq_q, pfd_q;

    tmr_mode_e mode;
    logic      run, edge_sel;
    logic      lvl, rise, fall, active_edge, return_edge;
    logic      tick, pw_en, measuring, pw_done;
    logic      wr_pre, wr_ctl, inc, ovf;

    always_comb begin
        mode        = tmr_mode_e'(ctrl_q[7:6]);
        run         = ctrl_q[4];
        edge_sel    = ctrl_q[3];
        active_edge = edge_sel ? fall : rise;
        return_edge = edge_sel ? rise : fall;
        pw_en       = run && (mode == MODE_PULSE);
        wr_pre      = bus_we && !bus_addr;
        wr_ctl      = bus_we && bus_addr;
    end

    tmr_sync_edge #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (ext_in),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    tmr_prescale #(.CW(CW)) u_psc (
        .clk         (clk),
        .rst_n       (rst_n),
        .psc_i       (ctrl_q[2:0]),
        .src_slow_i  (ctrl_q[5]),
        .slow_tick_i (slow_tick),
        .tick_o      (tick)
    );

    tmr_pw_fsm u_pw (
        .clk         (clk),
        .rst_n       (rst_n),
        .pw_en_i     (pw_en),
        .start_i     (active_edge),
        .stop_i      (return_edge),
        .measuring_o (measuring),
        .done_o      (pw_done)
    );

    logic unused_lvl;
    assign unused_lvl = lvl;

    always_comb begin
        inc = 1'b0;
        if (run) begin
            unique case (mode)
                MODE_EVENT: inc = active_edge;
                MODE_TIMER: inc = tick;
                MODE_PULSE: inc = measuring && tick;
                default:    inc = 1'b0;
            endcase
        end
        ovf = inc && (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= ovf ? preload_q : cnt_q + 1'b1;
        end else if (wr_pre && !run) begin
            cnt_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      preload_q <= '0;
        else if (wr_pre) preload_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q    <= '0;
        else if (wr_ctl)  ctrl_q    <= bus_wdata[CTRL_W-1:0] & CTRL_MASK;
        else if (pw_done) ctrl_q[4] <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            pfd_q <= 1'b0;
        end else begin
            if (ovf)          irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
            if (ovf)          pfd_q <= ~pfd_q;
        end
    end

    assign irq_flag  = irq_q;
    assign pfd_out   = pfd_q;
    assign bus_rdata = bus_addr ? CW'(ctrl_q) : cnt_q;

    // R4: overflow reloads from the preload value seen that cycle and raises the flag
    a_r4_overflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == $past(preload_q)) && irq_flag);
    // R4: the divider output moves only on overflow
    a_r4_pfd_only_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> $stable(pfd_out));
    // R10: the request flag is sticky until cleared
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
    // R2: without a count step or a stopped-state load the counter is frozen
    a_r2_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !(wr_pre && !run)) |=> $stable(cnt_q));
    // R8: the end of a measurement drops the run bit
    a_r8_run_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_done && !wr_ctl) |=> !ctrl_q[4]);
    // R1: the unused mode never produces a count step
    a_r1_off_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> !inc);
endmodule

// File: tb/tb_tmr_event_counter.sv
`timescale 1ns/1ps
module tb_tmr_event_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0, addr = 1'b0, ext = 1'b0, irq_clr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq, pfd;
    logic        w_we = 1'b0, w_addr = 1'b0, w_slow = 1'b0;
    logic [15:0] w_wdata = '0;
    logic [15:0] w_rdata;
    logic        w_irq, w_pfd;
    int          checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    tmr_event_counter #(.CW(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .ext_in(ext), .slow_tick(1'b0), .irq_clr(irq_clr),
        .irq_flag(irq), .pfd_out(pfd));

    tmr_event_counter #(.CW(16)) dut_wide (
        .clk(clk), .rst_n(rst_n), .bus_we(w_we), .bus_addr(w_addr), .bus_wdata(w_wdata),
        .bus_rdata(w_rdata), .ext_in(1'b0), .slow_tick(w_slow), .irq_clr(1'b0),
        .irq_flag(w_irq), .pfd_out(w_pfd));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic bw(input logic a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bww(input logic a, input logic [15:0] d);
        w_we = 1'b1; w_addr = a; w_wdata = d;
        @(negedge clk);
        w_we = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        addr = a; #1; v = int'(rdata);
    endtask

    task automatic rdw(input logic a, output int v);
        w_addr = a; #1; v = int'(w_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic lvl, input int n);
        ext = lvl; idle(n); ext = ~lvl;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        rd(0, v); check("R2 reset counter", v, 0);
        rd(1, v); check("R12 reset control", v, 0);
        check("R10 reset irq", int'(irq), 0);
        check("R4 reset pfd", int'(pfd), 0);

        // R12: narrow drops bit 5
        bw(1, 8'h2F); rd(1, v); check("R12 narrow unused bit", v, 8'h0F);
        bw(1, 8'h00);

        // R11: stopped-state preload write also loads counter
        bw(0, 8'h37); rd(0, v); check("R11 load while stopped", v, 8'h37);

        // R1: mode 00 with run set never counts
        bw(1, 8'h10); idle(20); rd(0, v); check("R1 mode off", v, 8'h37);
        bw(1, 8'h00);

        // R5: prescale sweep, window of 3 tick periods
        for (int p = 0; p < 8; p++) begin
            bw(1, 8'h80 | 8'(p));
            bw(0, 8'h00);
            bw(1, 8'h90 | 8'(p));
            idle(3 * (1 << p) - 1);
            bw(1, 8'h80 | 8'(p));
            rd(0, v); check($sformatf("R5 psc %0d", p), v, 3);
        end
        idle(10); rd(0, v); check("R2 stopped timer holds", v, 3);

        // R11: preload write while running leaves counter alone
        bw(1, 8'h50); bw(0, 8'hAA); rd(0, v); check("R11 no load while running", v, 3);
        bw(1, 8'h40);

        // R3: event counting on each edge polarity
        for (int es = 0; es < 2; es++) begin
            for (int np = 1; np <= 5; np += 2) begin
                bw(1, 8'h40 | 8'(es << 3));
                bw(0, 8'h00);
                bw(1, 8'h50 | 8'(es << 3));
                idle(2);
                for (int k = 0; k < np; k++) begin
                    pulse(1'b1, 2); idle(2);
                end
                idle(4);
                rd(0, v); check($sformatf("R3 edge %0d pulses %0d", es, np), v, np);
            end
        end
        rd(1, v); check("R8 event run bit kept", v, 8'h58);

        // R3: falling-edge mode ignores a rising edge
        bw(1, 8'h48); bw(0, 8'h00); bw(1, 8'h58);
        ext = 1'b1; idle(6); rd(0, v); check("R3 rise ignored", v, 0);
        ext = 1'b0; idle(6); rd(0, v); check("R3 fall counted", v, 1);
        bw(1, 8'h48);

        // R4: overflow in timer mode
        bw(0, 8'hFD);
        bw(1, 8'h50); bw(0, 8'h10);
        bw(1, 8'h90); idle(4); bw(1, 8'h80);
        rd(0, v); check("R4 timer overflow reload", v, 8'h12);
        check("R4 irq set", int'(irq), 1);
        check("R4 pfd toggled", int'(pfd), 1);

        // R10: sticky until cleared
        idle(10); check("R10 irq sticky", int'(irq), 1);
        irq_clr = 1'b1; idle(1); irq_clr = 1'b0;
        check("R10 irq cleared", int'(irq), 0);

        // R7/R8/R9: pulse-width, rising start
        bw(1, 8'hC0); bw(0, 8'h00);
        bw(1, 8'hD0); idle(3);
        pulse(1'b1, 7); idle(6);
        rd(0, v); check("R7 width 7", v, 7);
        rd(1, v); check("R8 run auto cleared", v, 8'hC0);
        pulse(1'b1, 4); idle(6);
        rd(0, v); check("R9 held after measure", v, 7);
        bw(1, 8'hD0); idle(3);
        pulse(1'b1, 3); idle(6);
        rd(0, v); check("R9 rearm accumulates", v, 10);

        // R7: falling start measures low time
        bw(1, 8'hC8); bw(0, 8'h00);
        ext = 1'b1; idle(5);
        bw(1, 8'hD8); idle(3);
        pulse(1'b0, 5); idle(6);
        rd(0, v); check("R7 low width 5", v, 5);
        ext = 1'b0; idle(6);
        rd(0, v); check("R9 idle return ignored", v, 5);

        // R4: overflow during pulse-width
        bw(1, 8'hC0); bw(0, 8'hFE);
        bw(1, 8'hD0); bw(0, 8'h20); idle(3);
        pulse(1'b1, 4); idle(6);
        rd(0, v); check("R4 pulse overflow", v, 8'h22);
        check("R4 pulse irq", int'(irq), 1);
        check("R4 pfd second toggle", int'(pfd), 0);

        // R12/R11/R6: wide variant
        bww(1, 16'h002F); rdw(1, v); check("R12 wide unused bits", v, 16'h0028);
        bww(1, 16'h0000);
        bww(0, 16'h1234); rdw(0, v); check("R11 wide load", v, 16'h1234);
        bww(0, 16'h0000);
        bww(1, 16'h0090); idle(19); bww(1, 16'h0080);
        rdw(0, v); check("R6 sys div4", v, 5);
        bww(0, 16'h0000);
        bww(1, 16'h00B0); idle(2);
        for (int k = 0; k < 6; k++) begin
            w_slow = 1'b1; idle(1); w_slow = 1'b0; idle(2);
        end
        bww(1, 16'h00A0);
        rdw(0, v); check("R6 slow tick", v, 6);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule